// File: doc/BRIEF.md
# Transmit Preamble and Inter-Packet Gap Inserter

This block sits in a transmit path between a byte-wide packet source and a byte-wide medium-independent output. For every packet the source offers, it first drives a run of preamble bytes (0x55) and one start-of-frame delimiter byte (0xD5) on the output, then passes the packet bytes through in order with transmit enable held high. After the last byte it holds transmit enable low for a programmable minimum gap before another packet may begin.

The preamble length and the gap length are selected per packet by small codes. In full duplex the preamble may be shortened and the gap narrowed across a wide range. In half duplex the preamble is always full length and only one narrowed gap value is allowed. A jam flag from the collision logic lets a new transmission start without waiting out the gap. The configuration inputs are captured when a packet starts. A change made while a packet is in flight therefore takes effect from the next packet.

Top module: `txpg_top`

## Requirements
- R1: While reset is held and on the first cycle after it, `tx_en` is low and, with `in_valid` low, `in_ready` is low.
- R2: Each packet is sent as N bytes of 0x55, then one byte of 0xD5, then the packet bytes in their input order. `tx_en` stays high for the whole frame and drops on the cycle after the last packet byte.
- R3: In full duplex (`full_duplex`=1) the preamble-length code gives N: code 0 gives 7, code 1 gives 5, code 2 gives 3, and the reserved code 3 gives 7.
- R4: In half duplex (`full_duplex`=0) N is 7 whatever the preamble-length code.
- R5: In full duplex, with `jam_active` low, `tx_en` stays low between two back-to-back packets for exactly 12 minus the gap code byte periods (96 minus 8 bit times per code step): code 0 gives 12, code 3 gives 9 and code 7 gives 5.
- R6: In half duplex, gap code 4 gives a gap of 8 byte periods and every other gap code gives 12.
- R7: While `jam_active` is high the minimum-gap rule is skipped. A waiting packet starts after a single low cycle of `tx_en`.
- R8: The duplex flag and both codes are captured when a packet starts. A change while the packet is in flight affects neither its preamble nor the gap that follows it, and the next packet uses the new values.
- R9: While idle, a byte offered without `in_sop` is accepted (`in_ready` high) and discarded. `tx_en` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Source byte valid |
| in_data | input | 8 | Source byte |
| in_sop | input | 1 | Marks the first byte of a packet |
| in_eop | input | 1 | Marks the last byte of a packet |
| in_ready | output | 1 | Block accepts the offered byte at this edge |
| full_duplex | input | 1 | 1 = full duplex, 0 = half duplex |
| pre_code | input | 2 | Preamble-length code |
| gap_code | input | 3 | Minimum-gap code |
| jam_active | input | 1 | Jam in progress; bypasses the gap rule |
| tx_en | output | 1 | Transmit enable |
| tx_data | output | 8 | Transmit byte |

## Verification
A wrong preamble counter or wrong captured length shows up in the first frame after the fault as a wrong count of 0x55 bytes before 0xD5, or as a shifted payload. A gap counter that is loaded with the wrong value, or that counts wrongly, shows up one gap later as a low period on `tx_en` that is longer or shorter than the code demands. The bench measures that period exactly between back-to-back packets. A state machine stuck in the wrong phase shows within a frame time, either as the source never seeing `in_ready` or as `tx_en` failing to drop.

// File: rtl/txpg_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the preamble and gap inserter.
package txpg_pkg;
    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] PRE_BYTE = 8'h55;
    localparam logic [BYTE_W-1:0] SFD_BYTE = 8'hD5;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRE  = 2'd1,
        ST_DATA = 2'd2,
        ST_TAIL = 2'd3
    } txpg_state_t;
endpackage

// File: rtl/txpg_cfg_decode.sv
`timescale 1ns/1ps
// Turns the duplex flag and the two codes into a preamble byte count and a
// gap length in byte periods. Purely combinational; assumes the caller
// captures the results at packet start.
module txpg_cfg_decode #(
    parameter int PRE_CODE_W     = 2,
    parameter int GAP_CODE_W     = 3,
    parameter int MAX_PRE        = 7,
    parameter int GAP_BASE_BYTES = 12,
    parameter int HD_GAP_CODE    = 4,
    localparam int PRE_CNT_W     = $clog2(MAX_PRE + 1),
    localparam int GAP_W         = $clog2(GAP_BASE_BYTES + 1)
) (
    input  logic                  full_duplex,
    input  logic [PRE_CODE_W-1:0] pre_code,
    input  logic [GAP_CODE_W-1:0] gap_code,
    output logic [PRE_CNT_W-1:0]  pre_len,
    output logic [GAP_W-1:0]      gap_len
);
    localparam logic [PRE_CNT_W-1:0] MAXP = PRE_CNT_W'(MAX_PRE);
    localparam logic [GAP_W-1:0]     GBASE = GAP_W'(GAP_BASE_BYTES);

    logic reserved_pre;

    // Preamble count: two bytes fewer per step in full duplex, full length otherwise.
    always_comb begin
        reserved_pre = &pre_code;
        if (!full_duplex || reserved_pre)
            pre_len = MAXP;
        else
            pre_len = MAXP - PRE_CNT_W'({pre_code, 1'b0});
    end

    // Gap length: one byte fewer per step in full duplex, one fixed option in half duplex.
    always_comb begin
        if (full_duplex)
            gap_len = GBASE - GAP_W'(gap_code);
        else if (gap_code == GAP_CODE_W'(HD_GAP_CODE))
            gap_len = GBASE - GAP_W'(HD_GAP_CODE);
        else
            gap_len = GBASE;
    end
endmodule

// File: rtl/txpg_gap_timer.sv
`timescale 1ns/1ps
// Counts down the minimum gap after a frame. Loaded on the edge where
// transmit enable drops; reports expiry once the programmed number of low
// byte periods has been covered. Assumes load values of at least 1.
module txpg_gap_timer #(
    parameter int GAP_BASE_BYTES = 12,
    localparam int GAP_W = $clog2(GAP_BASE_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [GAP_W-1:0] load_val,
    output logic             expired
);
    logic [GAP_W-1:0] cnt;

    // Down-counter: load with length minus one, then run to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val - 1'b1;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    // R5
    gap_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/txpg_seq.sv
`timescale 1ns/1ps
// Frame sequencer: waits for a start byte and an expired gap (or jam),
// captures the decoded configuration, emits preamble and delimiter, then
// forwards packet bytes until the end marker. Assumes the source keeps
// in_valid high during a packet; on underrun the last byte is held.
module txpg_seq #(
    parameter int MAX_PRE        = 7,
    parameter int GAP_BASE_BYTES = 12,
    localparam int PRE_CNT_W     = $clog2(MAX_PRE + 1),
    localparam int GAP_W         = $clog2(GAP_BASE_BYTES + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [txpg_pkg::BYTE_W-1:0] in_data,
    input  logic                        in_sop,
    input  logic                        in_eop,
    output logic                        in_ready,
    input  logic                        jam_active,
    input  logic                        gap_ok,
    input  logic [PRE_CNT_W-1:0]        pre_len,
    input  logic [GAP_W-1:0]            gap_len,
    output logic                        gap_load,
    output logic [GAP_W-1:0]            gap_load_val,
    output logic                        tx_en,
    output logic [txpg_pkg::BYTE_W-1:0] tx_data
);
    import txpg_pkg::*;

    txpg_state_t          state;
    logic [PRE_CNT_W-1:0] pre_cnt;
    logic [GAP_W-1:0]     gap_len_q;
    logic                 start;

    // Start and accept decisions for the current cycle.
    always_comb begin
        start    = (state == ST_IDLE) && in_valid && in_sop && (gap_ok || jam_active);
        in_ready = (state == ST_DATA) || ((state == ST_IDLE) && in_valid && !in_sop);
    end

    // Gap timer is armed on the edge where transmit enable drops.
    assign gap_load     = (state == ST_TAIL);
    assign gap_load_val = gap_len_q;

    // Phase register, preamble counter, captured gap and registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            pre_cnt   <= '0;
            gap_len_q <= '0;
            tx_en     <= 1'b0;
            tx_data   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state     <= ST_PRE;
                        pre_cnt   <= pre_len - 1'b1;
                        gap_len_q <= gap_len;
                        tx_en     <= 1'b1;
                        tx_data   <= PRE_BYTE;
                    end
                end
                ST_PRE: begin
                    if (pre_cnt == '0) begin
                        state   <= ST_DATA;
                        tx_data <= SFD_BYTE;
                    end else begin
                        pre_cnt <= pre_cnt - 1'b1;
                        tx_data <= PRE_BYTE;
                    end
                end
                ST_DATA: begin
                    if (in_valid) begin
                        tx_data <= in_data;
                        if (in_eop)
                            state <= ST_TAIL;
                    end
                end
                default: begin
                    state   <= ST_IDLE;
                    tx_en   <= 1'b0;
                    tx_data <= '0;
                end
            endcase
        end
    end

    // R2
    frame_opens_with_preamble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |-> (tx_data == PRE_BYTE));

    // R5
    start_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |-> $past(gap_ok || jam_active));

    // R3
    pre_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pre_cnt <= PRE_CNT_W'(MAX_PRE - 1));

    // R8
    gap_capture_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && $past(state) != ST_IDLE) |-> $stable(gap_len_q));

    // R9
    idle_accept_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !tx_en) |-> !in_sop);
endmodule

// File: rtl/txpg_top.sv
`timescale 1ns/1ps
// Transmit preamble and inter-packet gap inserter. Wires the configuration
// decoder, gap timer and frame sequencer. Assumes a continuous byte stream
// per packet from the source and a single byte clock.
module txpg_top #(
    parameter int PRE_CODE_W     = 2,
    parameter int GAP_CODE_W     = 3,
    parameter int MAX_PRE        = 7,
    parameter int GAP_BASE_BYTES = 12,
    parameter int HD_GAP_CODE    = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [7:0]            in_data,
    input  logic                  in_sop,
    input  logic                  in_eop,
    output logic                  in_ready,
    input  logic                  full_duplex,
    input  logic [PRE_CODE_W-1:0] pre_code,
    input  logic [GAP_CODE_W-1:0] gap_code,
    input  logic                  jam_active,
    output logic                  tx_en,
    output logic [7:0]            tx_data
);
    localparam int PRE_CNT_W = $clog2(MAX_PRE + 1);
    localparam int GAP_W     = $clog2(GAP_BASE_BYTES + 1);

    logic [PRE_CNT_W-1:0] pre_len;
    logic [GAP_W-1:0]     gap_len;
    logic [GAP_W-1:0]     gap_load_val;
    logic                 gap_load;
    logic                 gap_ok;

    txpg_cfg_decode #(
        .PRE_CODE_W     (PRE_CODE_W),
        .GAP_CODE_W     (GAP_CODE_W),
        .MAX_PRE        (MAX_PRE),
        .GAP_BASE_BYTES (GAP_BASE_BYTES),
        .HD_GAP_CODE    (HD_GAP_CODE)
    ) u_dec (
        .full_duplex (full_duplex),
        .pre_code    (pre_code),
        .gap_code    (gap_code),
        .pre_len     (pre_len),
        .gap_len     (gap_len)
    );

    txpg_gap_timer #(
        .GAP_BASE_BYTES (GAP_BASE_BYTES)
    ) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gap_load),
        .load_val (gap_load_val),
        .expired  (gap_ok)
    );

    txpg_seq #(
        .MAX_PRE        (MAX_PRE),
        .GAP_BASE_BYTES (GAP_BASE_BYTES)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_data      (in_data),
        .in_sop       (in_sop),
        .in_eop       (in_eop),
        .in_ready     (in_ready),
        .jam_active   (jam_active),
        .gap_ok       (gap_ok),
        .pre_len      (pre_len),
        .gap_len      (gap_len),
        .gap_load     (gap_load),
        .gap_load_val (gap_load_val),
        .tx_en        (tx_en),
        .tx_data      (tx_data)
    );

    // R2
    frame_end_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_en) |-> $past(gap_load));
endmodule

// File: tb/sim_txpg_top.sv
`timescale 1ns/1ps
module sim_txpg_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_sop = 1'b0;
    logic       in_eop = 1'b0;
    logic       in_ready;
    logic       full_duplex = 1'b1;
    logic [1:0] pre_code = '0;
    logic [2:0] gap_code = '0;
    logic       jam_active = 1'b0;
    logic       tx_en;
    logic [7:0] tx_data;

    int checks = 0;
    int fails = 0;

    // Monitor state
    logic [7:0] cap [0:63];
    int cap_len = 0;
    int lowcnt = 1000;
    int last_gap = 0;
    int done_cnt = 0;
    logic en_prev = 1'b0;

    always #5 clk = ~clk;

    txpg_top u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_sop(in_sop), .in_eop(in_eop), .in_ready(in_ready),
        .full_duplex(full_duplex), .pre_code(pre_code), .gap_code(gap_code),
        .jam_active(jam_active), .tx_en(tx_en), .tx_data(tx_data)
    );

    // Capture frames and measure low periods of tx_en between them.
    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_en) begin
                if (!en_prev) begin
                    last_gap = lowcnt;
                    cap_len = 0;
                end
                if (cap_len < 64) cap[cap_len] = tx_data;
                cap_len++;
                lowcnt = 0;
            end else begin
                if (en_prev) done_cnt++;
                lowcnt++;
            end
            en_prev = tx_en;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_pre(input bit fd, input int pc);
        if (!fd || pc == 3) return 7;
        return 7 - 2 * pc;
    endfunction

    function automatic int exp_gap(input bit fd, input int gc);
        if (fd) return 12 - gc;
        return (gc == 4) ? 8 : 12;
    endfunction

    task automatic push(input logic [7:0] d, input logic s, input logic e);
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_sop = s; in_eop = e;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic release_src();
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    endtask

    task automatic send_pkt(input int len, input int base);
        for (int i = 0; i < len; i++)
            push(8'(base + i), i == 0, i == len - 1);
        release_src();
    endtask

    task automatic wait_done(input int target);
        while (done_cnt < target) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_frame(input int npre, input int len, input int base, input string req);
        int bad = 0;
        int first_bad = -1;
        logic [7:0] e;
        chk(cap_len == npre + 1 + len, {req, " frame length"}, cap_len, npre + 1 + len);
        for (int i = 0; i < npre + 1 + len && i < 64; i++) begin
            if (i < npre) e = 8'h55;
            else if (i == npre) e = 8'hD5;
            else e = 8'(base + i - npre - 1);
            if (cap[i] !== e) begin
                bad++;
                if (first_bad < 0) first_bad = i;
            end
        end
        chk(bad == 0, {req, " frame bytes (count of wrong bytes)"}, bad, 0);
    endtask

    // R1: reset state
    task automatic t_reset();
        @(negedge clk);
        chk(tx_en == 1'b0, "R1 tx_en in reset", tx_en, 0);
        chk(in_ready == 1'b0, "R1 in_ready in reset", in_ready, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_en == 1'b0, "R1 tx_en after reset", tx_en, 0);
        chk(in_ready == 1'b0, "R1 in_ready after reset", in_ready, 0);
    endtask

    // R2 R3 R4: one frame's content
    task automatic t_frame(input bit fd, input int pc, input int len, input int base, input string req);
        int d0;
        @(negedge clk);
        full_duplex = fd; pre_code = 2'(pc); gap_code = '0;
        d0 = done_cnt;
        send_pkt(len, base);
        wait_done(d0 + 1);
        check_frame(exp_pre(fd, pc), len, base, req);
    endtask

    // R5 R6: gap between back-to-back packets
    task automatic t_gap(input bit fd, input int gc, input string req);
        int d0;
        @(negedge clk);
        full_duplex = fd; pre_code = '0; gap_code = 3'(gc);
        d0 = done_cnt;
        send_pkt(6, 8'h10);
        send_pkt(6, 8'h20);
        wait_done(d0 + 2);
        chk(last_gap == exp_gap(fd, gc), req, last_gap, exp_gap(fd, gc));
    endtask

    // R7: jam bypasses the gap
    task automatic t_jam();
        int d0;
        @(negedge clk);
        full_duplex = 1'b1; pre_code = '0; gap_code = '0; jam_active = 1'b1;
        d0 = done_cnt;
        send_pkt(5, 8'h30);
        send_pkt(5, 8'h40);
        wait_done(d0 + 2);
        chk(last_gap == 1, "R7 gap under jam", last_gap, 1);
        check_frame(7, 5, 8'h40, "R7 frame after jam");
        jam_active = 1'b0;
        repeat (15) @(negedge clk);
    endtask

    // R8: mid-packet configuration change
    task automatic t_midcfg();
        int d0;
        @(negedge clk);
        full_duplex = 1'b1; pre_code = 2'd0; gap_code = 3'd0;
        d0 = done_cnt;
        push(8'h50, 1'b1, 1'b0);
        push(8'h51, 1'b0, 1'b0);
        pre_code = 2'd2; gap_code = 3'd7;
        for (int i = 2; i < 8; i++) push(8'(8'h50 + i), 1'b0, i == 7);
        release_src();
        send_pkt(4, 8'h60);
        wait_done(d0 + 2);
        chk(last_gap == 12, "R8 gap keeps old code", last_gap, 12);
        check_frame(3, 4, 8'h60, "R8 next packet uses new preamble");
        send_pkt(4, 8'h70);
        wait_done(d0 + 3);
        chk(last_gap == 5, "R8 new gap code after change", last_gap, 5);
    endtask

    // R9: stray byte while idle is dropped
    task automatic t_drop();
        int d0;
        bit seen = 0;
        repeat (20) @(negedge clk);
        d0 = done_cnt;
        in_valid = 1'b1; in_sop = 1'b0; in_eop = 1'b0; in_data = 8'hAA;
        #1;
        chk(in_ready == 1'b1, "R9 stray byte accepted", in_ready, 1);
        @(negedge clk);
        in_valid = 1'b0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (tx_en) seen = 1;
        end
        chk(seen == 0, "R9 tx_en stays low", seen, 0);
        chk(done_cnt == d0, "R9 no frame sent", done_cnt, d0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_frame(1'b1, 0, 6, 8'h80, "R2 R3 fd code0");
        t_frame(1'b1, 1, 4, 8'h90, "R3 fd code1");
        t_frame(1'b1, 2, 9, 8'hA0, "R3 fd code2");
        t_frame(1'b1, 3, 3, 8'hB0, "R3 fd reserved code3");
        t_frame(1'b0, 2, 5, 8'hC0, "R4 hd code2");
        t_frame(1'b0, 1, 2, 8'hC8, "R4 hd code1");
        t_gap(1'b1, 0, "R5 fd gap code0");
        t_gap(1'b1, 3, "R5 fd gap code3");
        t_gap(1'b1, 7, "R5 fd gap code7");
        t_gap(1'b0, 4, "R6 hd gap code4");
        t_gap(1'b0, 7, "R6 hd gap code7");
        t_gap(1'b0, 2, "R6 hd gap code2");
        t_jam();
        t_midcfg();
        t_drop();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule